// File: doc/BRIEF.md
# Indexed Host Register Port

This block is the host-facing register file of a larger controller. The host reaches it over a shared 16-bit bus. The bus is controlled by a chip select, a command/data select, a read/write line, an address strobe and a data strobe. The host cannot address registers directly. It first performs a command write, which loads a 5-bit index. Every later data access, whether a read or a write, targets the register that the index names. The index keeps its value until the next command write.

All strobes are sampled on the block's own clock, so the block sees their edges one clock after they happen. Chip select and command/data are captured while the address strobe is low and held once it goes high. A read drives the bus and pulls the transmit enable low from the data-strobe fall until the strobe is released. A write commits on the data-strobe rise. Two index values name one shared page-pointer register, and a flag records which of the two names wrote it last. The page-pointer names cannot be read back. Indices that have no register are inert. The mode registers and the page pointer are also brought out as ports for the neighbouring logic.

Top module: `idx_regif`

## Requirements
- R1: A write with command/data high loads the index from bus_in[4:0]. The index then persists across any number of data accesses. Reset sets it to 0.
- R2: A write with command/data low stores bus_in into the indexed register on the first clock that samples ds_n high after the access. The new value appears at the ports after that edge.
- R3: A data read is recognised on the clock that first samples ds_n low. From the following cycle bus_oe is 1, txen_n is 0 and bus_out carries the register value. All three return to idle (bus_oe 0, txen_n 1, bus_out 0) after the clock that samples ds_n high.
- R4: cs_n and cmd_sel pass through to the access logic while as_n is low. They are held at their last value while as_n is high, so their later changes have no effect on the access.
- R5: txen_n and rxen_n are never both 0. rxen_n is 0 over a recognised write, from the cycle after the ds_n fall until the cycle after the ds_n rise.
- R6: A write to index 0x10 or index 0x11 updates the single page_ptr register. page_soft becomes 1 after a write to 0x11 and 0 after a write to 0x10.
- R7: Writes to indices 0x0D–0x0F and 0x19–0x1F change no register, and reads of those indices return 0.
- R8: Reads of index 0x10 or index 0x11 return 0 while bus_oe is still asserted, even after page_ptr has been written.
- R9: An access with command/data high and read selected does not drive the bus, does not lower either enable, and leaves the index unchanged.
- R10: A low rst_n clears mode1, mode2, page_ptr, page_soft and the index. It also leaves bus_oe at 0 and both enables at 1.
- R11: Reserved bits are stored as 0. These are bit 15 of mode1 (index 0x00) and bits 15:8 of mode2 (index 0x01). Indices 0x02–0x0C and 0x12–0x18 store all 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| cmd_sel | input | 1 | 1 selects an index (command) access, 0 selects a data access |
| rd_wr_n | input | 1 | 1 selects a read, 0 selects a write |
| as_n | input | 1 | Address strobe; the selects are held while it is high |
| ds_n | input | 1 | Data strobe, active low |
| bus_in | input | 16 | Incoming bus data |
| bus_out | output | 16 | Read data; 0 when not driving |
| bus_oe | output | 1 | Bus driver enable |
| txen_n | output | 1 | Transceiver enable toward the host, active low |
| rxen_n | output | 1 | Transceiver enable from the host, active low |
| mode1 | output | 16 | Contents of register 0x00 |
| mode2 | output | 16 | Contents of register 0x01 |
| page_ptr | output | 16 | Shared page-pointer storage |
| page_soft | output | 1 | 1 when index 0x11 wrote the page pointer last |

## Verification
The bench builds the block with its default 16-bit data width and 5-bit index. These defaults cover the whole 32-entry index space. That space includes both inert ranges, the aliased page-pointer pair and the masked mode registers. A behavioural model tracks the index, the register contents and the expected state of the enables. Every access changes the selects after the address strobe closes, which tests the hold behaviour in both directions.

// File: rtl/regif_pkg.sv
package regif_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_READ,
    ACC_WIDX,
    ACC_WREG
  } acc_e;

  localparam int unsigned SLOT_MODE1     = 0;
  localparam int unsigned SLOT_MODE2     = 1;
  localparam int unsigned SLOT_PAGE_HARD = 16;
  localparam int unsigned SLOT_PAGE_SOFT = 17;

  // Kind of access selected by the held command/data and read/write lines.
  function automatic acc_e decode_access(logic cmd, logic rd);
    if (cmd && !rd)  return ACC_WIDX;
    if (!cmd && rd)  return ACC_READ;
    if (!cmd && !rd) return ACC_WREG;
    return ACC_IDLE;  // command read: undefined, treated as no access
  endfunction

  // Indices that have a register behind them.
  function automatic logic idx_assigned(int unsigned i);
    return !((i >= 13 && i <= 15) || (i >= 25));
  endfunction

  // Indices whose content may be returned on a read.
  function automatic logic idx_readable(int unsigned i);
    return idx_assigned(i) && (i != SLOT_PAGE_HARD) && (i != SLOT_PAGE_SOFT);
  endfunction

  // Storage slot behind an index; the two page names share one slot.
  function automatic int unsigned idx_slot(int unsigned i);
    return (i == SLOT_PAGE_SOFT) ? SLOT_PAGE_HARD : i;
  endfunction

  // Bits that are kept on a write; reserved bits are forced to zero.
  function automatic logic [31:0] keep_mask(int unsigned i, int unsigned dw);
    logic [31:0] all;
    all = (dw >= 32) ? 32'hFFFF_FFFF : ((32'd1 << dw) - 32'd1);
    if (i == SLOT_MODE1) return all >> 1;
    if (i == SLOT_MODE2) return all >> (dw - dw / 2);
    return all;
  endfunction

endpackage

// File: rtl/regif_strobe.sv
module regif_strobe
  import regif_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic cmd_sel,
  input  logic rd_wr_n,
  input  logic as_n,
  input  logic ds_n,
  output logic rd_go,
  output logic idx_go,
  output logic wr_go,
  output logic drive,
  output logic rx_on
);

  logic cs_hold, cmd_hold;
  logic cs_eff, cmd_eff;
  logic ds_q, ds_fall;
  acc_e st, st_nx, kind;

  // Selects follow the pins while the address strobe is low, hold otherwise.
  assign cs_eff  = as_n ? cs_hold  : cs_n;
  assign cmd_eff = as_n ? cmd_hold : cmd_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_hold  <= 1'b1;
      cmd_hold <= 1'b0;
      ds_q     <= 1'b1;
      st       <= ACC_IDLE;
    end else begin
      cs_hold  <= cs_eff;
      cmd_hold <= cmd_eff;
      ds_q     <= ds_n;
      st       <= st_nx;
    end
  end

  assign ds_fall = ds_q && !ds_n;
  assign kind    = decode_access(cmd_eff, rd_wr_n);

  always_comb begin
    st_nx = st;
    if (ds_n)                  st_nx = ACC_IDLE;
    else if (ds_fall && !cs_eff) st_nx = kind;
  end

  assign rd_go  = ds_fall && !cs_eff && (kind == ACC_READ);
  assign idx_go = ds_n && (st == ACC_WIDX);
  assign wr_go  = ds_n && (st == ACC_WREG);
  assign drive  = (st == ACC_READ);
  assign rx_on  = (st == ACC_WIDX) || (st == ACC_WREG);

endmodule

// File: rtl/regif_store.sv
module regif_store
  import regif_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_go,
  input  logic          wr_go,
  input  logic          rd_go,
  input  logic [DW-1:0] bus_in,
  output logic [IW-1:0] idx_q,
  output logic [DW-1:0] rd_word,
  output logic [DW-1:0] mode1,
  output logic [DW-1:0] mode2,
  output logic [DW-1:0] page_ptr,
  output logic          page_soft
);

  localparam int NREG = 1 << IW;

  logic [DW-1:0] cells [NREG];
  logic [IW-1:0] wr_slot;
  logic          wr_ok;
  logic          rd_ok;
  logic          page_hit;

  assign wr_slot  = IW'(idx_slot(int'(idx_q)));
  assign wr_ok    = idx_assigned(int'(idx_q));
  assign rd_ok    = idx_readable(int'(idx_q));
  assign page_hit = (int'(idx_q) == SLOT_PAGE_HARD) || (int'(idx_q) == SLOT_PAGE_SOFT);

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    localparam logic [DW-1:0] KEEP = DW'(keep_mask(g, DW));
    logic [DW-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   val <= '0;
      else if (wr_go && wr_ok && wr_slot == IW'(g)) val <= bus_in & KEEP;
    end
    assign cells[g] = val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      rd_word   <= '0;
      page_soft <= 1'b0;
    end else begin
      if (idx_go)            idx_q     <= bus_in[IW-1:0];
      if (rd_go)             rd_word   <= rd_ok ? cells[idx_q] : '0;
      if (wr_go && page_hit) page_soft <= (int'(idx_q) == SLOT_PAGE_SOFT);
    end
  end

  assign mode1    = cells[SLOT_MODE1];
  assign mode2    = cells[SLOT_MODE2];
  assign page_ptr = cells[SLOT_PAGE_HARD];

endmodule

// File: rtl/idx_regif.sv
module idx_regif #(
  parameter int DW = 16,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          cmd_sel,
  input  logic          rd_wr_n,
  input  logic          as_n,
  input  logic          ds_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          txen_n,
  output logic          rxen_n,
  output logic [DW-1:0] mode1,
  output logic [DW-1:0] mode2,
  output logic [DW-1:0] page_ptr,
  output logic          page_soft
);

  logic          rd_go, idx_go, wr_go, drive, rx_on;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] rd_word;

  regif_strobe u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .cmd_sel (cmd_sel),
    .rd_wr_n (rd_wr_n),
    .as_n    (as_n),
    .ds_n    (ds_n),
    .rd_go   (rd_go),
    .idx_go  (idx_go),
    .wr_go   (wr_go),
    .drive   (drive),
    .rx_on   (rx_on)
  );

  regif_store #(.DW(DW), .IW(IW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_go    (idx_go),
    .wr_go     (wr_go),
    .rd_go     (rd_go),
    .bus_in    (bus_in),
    .idx_q     (idx_q),
    .rd_word   (rd_word),
    .mode1     (mode1),
    .mode2     (mode2),
    .page_ptr  (page_ptr),
    .page_soft (page_soft)
  );

  assign bus_oe  = drive;
  assign bus_out = drive ? rd_word : '0;
  assign txen_n  = !drive;
  assign rxen_n  = !rx_on;

endmodule

// File: rtl/regif_chk.sv
module regif_chk #(
  parameter int DW = 16,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ds_n,
  input logic          txen_n,
  input logic          rxen_n,
  input logic          idx_go,
  input logic          wr_go,
  input logic [IW-1:0] idx_q,
  input logic [DW-1:0] mode1,
  input logic [DW-1:0] mode2,
  input logic          page_soft
);

  assert_enables_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!txen_n && !rxen_n));

  assert_drive_follows_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txen_n) |-> !$past(ds_n));

  assert_release_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ds_n |=> txen_n);

  assert_index_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_go |=> $stable(idx_q));

  assert_mode1_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && idx_q != '0) |=> $stable(mode1));

  assert_soft_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && idx_q == IW'(17)) |=> page_soft);

  assert_mode2_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode2[DW-1:DW/2] == '0);

endmodule

bind idx_regif regif_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ds_n      (ds_n),
  .txen_n    (txen_n),
  .rxen_n    (rxen_n),
  .idx_go    (idx_go),
  .wr_go     (wr_go),
  .idx_q     (idx_q),
  .mode1     (mode1),
  .mode2     (mode2),
  .page_soft (page_soft)
);

// File: tb/tb_idx_regif.sv
`timescale 1ns/1ps
module tb_idx_regif;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, cs_n, cmd_sel, rd_wr_n, as_n, ds_n;
  logic [15:0] bus_in;
  logic [15:0] bus_out, mode1, mode2, page_ptr;
  logic        bus_oe, txen_n, rxen_n, page_soft;

  idx_regif dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_sel(cmd_sel), .rd_wr_n(rd_wr_n),
    .as_n(as_n), .ds_n(ds_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .txen_n(txen_n), .rxen_n(rxen_n), .mode1(mode1), .mode2(mode2),
    .page_ptr(page_ptr), .page_soft(page_soft)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Behavioural reference state
  logic [15:0] m_regs [32];
  logic [15:0] m_page;
  logic        m_soft;
  logic [4:0]  m_idx;
  bit          exp_drive, exp_rx;
  logic [15:0] exp_word;

  function automatic bit inert(int i);
    return (i >= 13 && i <= 15) || (i >= 25);
  endfunction

  function automatic logic [15:0] model_read(int i);
    if (inert(i) || i == 16 || i == 17) return 16'h0000;
    return m_regs[i];
  endfunction

  task automatic model_write(int i, logic [15:0] d);
    if (inert(i)) return;
    if (i == 16 || i == 17) begin
      m_page = d;
      m_soft = (i == 17);
    end else if (i == 0) m_regs[i] = {1'b0, d[14:0]};
    else if (i == 1)     m_regs[i] = {8'h00, d[7:0]};
    else                 m_regs[i] = d;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_regs[i] = 16'h0000;
    m_page = 16'h0000; m_soft = 1'b0; m_idx = 5'd0;
    exp_drive = 0; exp_rx = 0;
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock; outputs compared with the model every cycle.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check("R3 bus_oe",   {15'd0, bus_oe},    {15'd0, exp_drive});
    check("R5 txen_n",   {15'd0, txen_n},    {15'd0, !exp_drive});
    check("R5 rxen_n",   {15'd0, rxen_n},    {15'd0, !exp_rx});
    check("R3 bus_out",  bus_out,            exp_drive ? exp_word : 16'h0000);
    check("R2 mode1",    mode1,              m_regs[0]);
    check("R11 mode2",   mode2,              m_regs[1]);
    check("R6 page_ptr", page_ptr,           m_page);
    check("R6 page_soft",{15'd0, page_soft}, {15'd0, m_soft});
  endtask

  task automatic access(input bit cmd, input bit rd, input logic [15:0] data,
                        input bit sel, output logic [15:0] got);
    bit hit_rd, hit_wr;
    hit_rd = sel && !cmd && rd;
    hit_wr = sel && !rd;
    cs_n = !sel; cmd_sel = cmd; rd_wr_n = rd; as_n = 1'b0; bus_in = data;
    tick();
    // address strobe closes; the pins now change and must be ignored (R4)
    as_n = 1'b1; cs_n = sel; cmd_sel = !cmd;
    tick();
    exp_word = model_read(m_idx);
    ds_n = 1'b0; exp_drive = hit_rd; exp_rx = hit_wr;
    tick();
    got = bus_out;
    tick();
    ds_n = 1'b1; exp_drive = 0; exp_rx = 0;
    if (hit_wr) begin
      if (cmd) m_idx = data[4:0];
      else     model_write(m_idx, data);
    end
    tick();
    cs_n = 1'b1;
  endtask

  task automatic set_idx(int i);
    logic [15:0] g;
    access(1'b1, 1'b0, 16'(i) | 16'hA5E0, 1'b1, g);
  endtask

  task automatic put(logic [15:0] d);
    logic [15:0] g;
    access(1'b0, 1'b0, d, 1'b1, g);
  endtask

  task automatic get(string tag, logic [15:0] exp);
    logic [15:0] g;
    access(1'b0, 1'b1, 16'h0000, 1'b1, g);
    check(tag, g, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] g;
    rst_n = 1'b0; cs_n = 1'b1; cmd_sel = 1'b0; rd_wr_n = 1'b1;
    as_n = 1'b1; ds_n = 1'b1; bus_in = 16'h0000;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();  // R10: reset state compared by tick
    get("R10 index zero after reset, mode1 reads 0", 16'h0000);

    // R11 / R2: masked mode registers
    set_idx(0); put(16'hFFFF); get("R11 mode1 bit15 reserved", 16'h7FFF);
    set_idx(1); put(16'hABCD); get("R11 mode2 high byte reserved", 16'h00CD);

    // R1: index persists over repeated accesses; R2 full-width registers
    set_idx(5); put(16'h1234);
    get("R1 first read idx5", 16'h1234);
    get("R1 second read idx5", 16'h1234);
    set_idx(24); put(16'hBEEF); get("R2 idx24", 16'hBEEF);
    set_idx(2); put(16'h5A5A); get("R2 idx2", 16'h5A5A);

    // R6 / R8: aliased write-only page pointer
    set_idx(16); put(16'h1111); get("R8 hard page reads zero", 16'h0000);
    set_idx(17); put(16'h2222); get("R8 soft page reads zero", 16'h0000);
    check("R6 soft flag after soft write", {15'd0, page_soft}, 16'h0001);
    set_idx(16); put(16'h3333);
    check("R6 shared storage", page_ptr, 16'h3333);
    check("R6 hard flag after hard write", {15'd0, page_soft}, 16'h0000);

    // R7: inert indices
    set_idx(13); put(16'hFFFF); get("R7 read idx13", 16'h0000);
    set_idx(15); put(16'h7777); get("R7 read idx15", 16'h0000);
    set_idx(25); put(16'h4444); get("R7 read idx25", 16'h0000);
    set_idx(31); put(16'hCAFE); get("R7 read idx31", 16'h0000);
    set_idx(5);  get("R7 idx5 untouched", 16'h1234);

    // R9: command read does nothing; index stays at 5
    access(1'b1, 1'b1, 16'h0003, 1'b1, g);
    check("R9 no drive on command read", g, 16'h0000);
    get("R9 index kept", 16'h1234);

    // R4: deselected at address strobe, later select ignored
    access(1'b1, 1'b0, 16'h0002, 1'b0, g);
    get("R4 index not loaded when cs high at strobe", 16'h1234);
    access(1'b0, 1'b0, 16'h9999, 1'b0, g);
    get("R4 data not written when cs high at strobe", 16'h1234);

    // R10: reset mid-run
    set_idx(0); put(16'h0F0F);
    @(negedge clk); rst_n = 1'b0;
    model_reset();
    tick();
    rst_n = 1'b1;
    tick();
    get("R10 mode1 cleared", 16'h0000);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule